// File: doc/BRIEF.md
# Attribute-Selected Write-Policy Data Cache

This block is a small direct-mapped data cache placed between a processor-side request port and a word-wide memory port. Each request arrives with its own memory attributes: a cacheable flag, a bufferable flag and a three-bit allocation-type field. These are normally produced by an address-region checker. The cache applies them on that access alone. A non-cacheable request bypasses the line store and becomes one plain memory transfer. A cacheable request uses write-back when the bufferable flag is set and write-through when it is clear. Reads always allocate. Writes allocate only when the type field equals 3'b001.

Lines are 32 bytes long, which is eight 32-bit words. Each line fill or write-back is eight word handshakes on the memory port, issued in ascending word order. A miss that displaces a dirty line first writes the victim back and then fetches the new line. A clean victim is dropped without any memory write. A flush request walks every line in index order, writes back the dirty lines, clears their dirty bits and reports completion with a one-cycle pulse.

The controller is one state machine with these states:
- IDLE waits. It goes to FL_SCAN on a flush request, which has priority, and otherwise to LOOKUP on a request.
- LOOKUP decides the path. It goes to SINGLE for a bypass, a write-through write hit or a non-allocating write miss. It goes to RESPOND for a read hit or a write-back write hit. It goes to EVICT for an allocating miss over a dirty victim, and to FILL for an allocating miss over a clean or invalid line.
- EVICT goes to FILL after its eighth beat.
- FILL goes back to LOOKUP after its eighth beat, and the access then completes as a hit.
- SINGLE goes to RESPOND on its handshake.
- RESPOND returns to IDLE.
- FL_SCAN goes to FL_WB on a dirty line, otherwise to the next index, and to FL_END after the last index.
- FL_WB returns to FL_SCAN after its eighth beat, or goes to FL_END after the last index.
- FL_END returns to IDLE.

Top module: `polcache_top`

## Requirements
- R1: After reset, every line is invalid, no line is dirty, and mem_valid, cpu_done and flush_done are low.
- R2: With cpu_cacheable=0, a read or a write becomes exactly one memory transfer at the request address, whatever the other attribute bits are. The read returns the memory word, and the line store is not changed.
- R3: A cacheable read miss fetches the line with eight read beats at the line-aligned address, word 0 first, ascending by 4 bytes. It then returns the requested word.
- R4: A cacheable read hit returns the stored word and makes no memory transfer.
- R5: A cacheable write hit with cpu_bufferable=1 (write-back) updates only the line store and marks the line dirty. It makes no memory transfer.
- R6: A cacheable write hit with cpu_bufferable=0 (write-through) updates the line store and issues one memory write of the same word.
- R7: A cacheable write miss with cpu_tex=3'b001 first fills the line and then completes as a write hit under R5 or R6.
- R8: A cacheable write miss with any cpu_tex value other than 3'b001 becomes one memory write, and the line store is left unchanged.
- R9: A miss that replaces a clean valid line issues only the eight fill reads.
- R10: A miss that replaces a dirty line first issues eight write beats of the victim line, word 0 first and ascending, at the victim's own address. It then issues the eight fill reads.
- R11: A one-cycle flush_req pulse while idle writes back each dirty line in ascending index order and clears its dirty bit. Clean lines are skipped. flush_done then pulses for one cycle.
- R12: While mem_valid is high and mem_ready is low, mem_valid, mem_write and mem_addr hold their values into the next cycle.
- R13: Each request is answered by a single one-cycle cpu_done pulse. For a read, cpu_rdata holds the read word during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present; held until cpu_done |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_cacheable | input | 1 | Access may use the cache |
| cpu_bufferable | input | 1 | 1 = write-back, 0 = write-through |
| cpu_tex | input | 3 | Allocation type; 3'b001 enables write allocation |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| flush_req | input | 1 | Start a flush of all dirty lines |
| flush_done | output | 1 | One-cycle flush completion pulse |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | 1 = memory write beat |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The hardest situations to reach are those where policies mix inside one line. Examples are a dirty line whose eviction is triggered by an allocating write, and a line that is write-back dirty while an uncached access to the same address goes to memory. The stimulus builds these step by step: it fills all eight lines, dirties half of them with write-back hits and writes through the other half. It then aims misses of other tags at chosen indices. A sweep over every allocation-type value and both bufferable settings checks that only 3'b001 allocates on a write miss. The memory model inserts pseudo-random wait states throughout the run, so every burst also exercises the stall-hold rule.

// File: rtl/polcache_pkg.sv
package polcache_pkg;

    typedef struct packed {
        logic       cacheable;
        logic       bufferable;
        logic [2:0] tex;
    } acc_attr_t;

    localparam logic [2:0] TEX_RW_ALLOC = 3'b001;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOOKUP,
        S_EVICT,
        S_FILL,
        S_SINGLE,
        S_RESPOND,
        S_FL_SCAN,
        S_FL_WB,
        S_FL_END
    } cstate_t;

endpackage

// File: rtl/polcache_attr.sv
module polcache_attr
    import polcache_pkg::*;
(
    input  acc_attr_t attr,
    output logic      bypass,
    output logic      write_back,
    output logic      write_alloc
);

    always_comb begin
        bypass      = !attr.cacheable;
        write_back  = attr.cacheable && attr.bufferable;
        write_alloc = attr.cacheable && (attr.tex == TEX_RW_ALLOC);
    end

endmodule

// File: rtl/polcache_store.sv
module polcache_store #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 24,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  tag_out,
    output logic              valid_out,
    output logic              dirty_out,
    output logic              any_dirty,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_done,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              dirty_set,
    input  logic              dirty_clr
);

    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;

    logic [DATA_W-1:0] data_q [LINES*WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;

    assign rd_data   = data_q[{idx, rd_word}];
    assign tag_out   = tag_q[idx];
    assign valid_out = valid_q[idx];
    assign dirty_out = dirty_q[idx];
    assign any_dirty = |dirty_q;

    always_ff @(posedge clk) begin
        if (wr_en) data_q[{idx, wr_word}] <= wr_data;
        if (fill_done) tag_q[idx] <= fill_tag;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel;
        assign sel = (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end else if (sel && fill_done) begin
                valid_q[i] <= 1'b1;
                dirty_q[i] <= 1'b0;
            end else if (sel && dirty_set) begin
                dirty_q[i] <= 1'b1;
            end else if (sel && dirty_clr) begin
                dirty_q[i] <= 1'b0;
            end
        end

        // R5
        dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q[i] |-> valid_q[i]);
    end

endmodule

// File: rtl/polcache_top.sv
module polcache_top
    import polcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_cacheable,
    input  logic              cpu_bufferable,
    input  logic [2:0]        cpu_tex,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BOFF_W;

    cstate_t state, next;

    logic              rq_write;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    acc_attr_t         rq_attr;
    logic [OFF_W-1:0]  cnt;
    logic [IDX_W-1:0]  fl_idx;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [OFF_W-1:0]  rq_word;
    assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
    assign rq_idx  = rq_addr[BOFF_W+OFF_W +: IDX_W];
    assign rq_word = rq_addr[BOFF_W +: OFF_W];

    logic byp, wback, walloc;
    polcache_attr u_attr (
        .attr        (rq_attr),
        .bypass      (byp),
        .write_back  (wback),
        .write_alloc (walloc)
    );

    logic [IDX_W-1:0]  st_idx;
    logic [OFF_W-1:0]  st_rword, st_wword;
    logic [DATA_W-1:0] st_rdata, st_wdata;
    logic [TAG_W-1:0]  st_tag;
    logic st_valid, st_dirty, st_any_dirty;
    logic st_wr_en, st_fill_done, st_dirty_set, st_dirty_clr;

    polcache_store #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (st_idx),
        .rd_word   (st_rword),
        .rd_data   (st_rdata),
        .tag_out   (st_tag),
        .valid_out (st_valid),
        .dirty_out (st_dirty),
        .any_dirty (st_any_dirty),
        .wr_en     (st_wr_en),
        .wr_word   (st_wword),
        .wr_data   (st_wdata),
        .fill_done (st_fill_done),
        .fill_tag  (rq_tag),
        .dirty_set (st_dirty_set),
        .dirty_clr (st_dirty_clr)
    );

    logic flush_phase, hit, beat_last, fl_last;
    assign flush_phase = (state == S_FL_SCAN) || (state == S_FL_WB) || (state == S_FL_END);
    assign st_idx      = flush_phase ? fl_idx : rq_idx;
    assign hit         = st_valid && (st_tag == rq_tag);
    assign beat_last   = mem_ready && (cnt == OFF_W'(WORDS - 1));
    assign fl_last     = (fl_idx == IDX_W'(NUM_LINES - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next;
    end

    // Transitions
    always_comb begin
        next = state;
        unique case (state)
            S_IDLE: begin
                if (flush_req)      next = S_FL_SCAN;
                else if (cpu_valid) next = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (byp)                          next = S_SINGLE;
                else if (hit)                     next = (rq_write && !wback) ? S_SINGLE : S_RESPOND;
                else if (!rq_write || walloc)     next = (st_valid && st_dirty) ? S_EVICT : S_FILL;
                else                              next = S_SINGLE;
            end
            S_EVICT:   if (beat_last) next = S_FILL;
            S_FILL:    if (beat_last) next = S_LOOKUP;
            S_SINGLE:  if (mem_ready) next = S_RESPOND;
            S_RESPOND: next = S_IDLE;
            S_FL_SCAN: begin
                if (st_valid && st_dirty) next = S_FL_WB;
                else if (fl_last)         next = S_FL_END;
            end
            S_FL_WB:   if (beat_last) next = fl_last ? S_FL_END : S_FL_SCAN;
            S_FL_END:  next = S_IDLE;
            default:   next = S_IDLE;
        endcase
    end

    // Outputs and store controls
    always_comb begin
        mem_valid    = 1'b0;
        mem_write    = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        st_rword     = rq_word;
        st_wword     = rq_word;
        st_wdata     = rq_wdata;
        st_wr_en     = 1'b0;
        st_fill_done = 1'b0;
        st_dirty_set = 1'b0;
        st_dirty_clr = 1'b0;
        cpu_done     = 1'b0;
        flush_done   = 1'b0;
        unique case (state)
            S_LOOKUP: begin
                if (!byp && hit && rq_write) begin
                    st_wr_en     = 1'b1;
                    st_dirty_set = wback;
                end
            end
            S_EVICT, S_FL_WB: begin
                st_rword     = cnt;
                mem_valid    = 1'b1;
                mem_write    = 1'b1;
                mem_addr     = {st_tag, st_idx, cnt, {BOFF_W{1'b0}}};
                mem_wdata    = st_rdata;
                st_dirty_clr = (state == S_FL_WB) && beat_last;
            end
            S_FILL: begin
                mem_valid    = 1'b1;
                mem_addr     = {rq_tag, rq_idx, cnt, {BOFF_W{1'b0}}};
                st_wword     = cnt;
                st_wdata     = mem_rdata;
                st_wr_en     = mem_ready;
                st_fill_done = beat_last;
            end
            S_SINGLE: begin
                mem_valid = 1'b1;
                mem_write = rq_write;
                mem_addr  = rq_addr;
                mem_wdata = rq_wdata;
            end
            S_RESPOND: cpu_done   = 1'b1;
            S_FL_END:  flush_done = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;

    // Request capture, beat counter, flush walker, read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_write <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
            rq_attr  <= '0;
            cnt      <= '0;
            fl_idx   <= '0;
            rdata_q  <= '0;
        end else begin
            if (state == S_IDLE && !flush_req && cpu_valid) begin
                rq_write <= cpu_write;
                rq_addr  <= cpu_addr;
                rq_wdata <= cpu_wdata;
                rq_attr  <= '{cacheable: cpu_cacheable, bufferable: cpu_bufferable, tex: cpu_tex};
            end
            if (state == S_IDLE) fl_idx <= '0;
            if ((state == S_EVICT || state == S_FILL || state == S_FL_WB) && mem_ready)
                cnt <= cnt + 1'b1;
            if (state == S_FL_SCAN && !(st_valid && st_dirty) && !fl_last)
                fl_idx <= fl_idx + 1'b1;
            if (state == S_FL_WB && beat_last && !fl_last)
                fl_idx <= fl_idx + 1'b1;
            if (state == S_LOOKUP && !byp && hit && !rq_write)
                rdata_q <= st_rdata;
            if (state == S_SINGLE && mem_ready && !rq_write)
                rdata_q <= mem_rdata;
        end
    end

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R11
    flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !st_any_dirty);

    // R5
    wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOOKUP && !byp && hit && rq_write && wback) |=> !mem_valid);

    // R10
    evict_to_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVICT && beat_last) |=> (state == S_FILL && !mem_write));

endmodule

// File: tb/polcache_top_tb.sv
module polcache_top_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cpu_valid = 0, cpu_write = 0, cpu_cacheable = 0, cpu_bufferable = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic [2:0]  cpu_tex = 0;
    logic        flush_req = 0;
    logic        cpu_done, flush_done, mem_valid, mem_write;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready;

    polcache_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_cacheable(cpu_cacheable),
        .cpu_bufferable(cpu_bufferable), .cpu_tex(cpu_tex), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .flush_req(flush_req), .flush_done(flush_done),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model with pseudo-random wait states and a transfer log
    logic [31:0] mem [256];
    logic [7:0]  lfsr;
    logic        log_we   [1024];
    logic [31:0] log_addr [1024];
    int          log_n = 0;

    function automatic logic [31:0] init_w(logic [31:0] a);
        return 32'h5A00_0000 | (a >> 2);
    endfunction

    assign mem_ready = lfsr[0] | lfsr[1];
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= 8'h5B;
            for (int i = 0; i < 256; i++) mem[i] <= init_w(32'(i * 4));
        end else begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (mem_valid && mem_ready) begin
                log_we[log_n]   <= mem_write;
                log_addr[log_n] <= mem_addr;
                log_n           <= log_n + 1;
                if (mem_write) mem[mem_addr[9:2]] <= mem_wdata;
            end
        end
    end

    // Stall-hold monitor
    int          stall_viol = 0, stalls = 0;
    logic        prev_stall = 0;
    logic [31:0] prev_addr = 0;
    logic        prev_we = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && (!mem_valid || mem_addr !== prev_addr || mem_write !== prev_we))
                stall_viol++;
            prev_stall = mem_valid && !mem_ready;
            if (prev_stall) stalls++;
            prev_addr = mem_addr;
            prev_we   = mem_write;
        end
    end

    int n_chk = 0, n_fail = 0;
    logic [31:0] last_rd;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] A(int t, int i, int w);
        return 32'(t * 256 + i * 32 + w * 4);
    endfunction

    function automatic logic [31:0] mw(logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    function automatic bit burst_ok(int b, bit we, logic [31:0] a0);
        for (int k = 0; k < 8; k++)
            if (log_we[b+k] !== we || log_addr[b+k] !== a0 + 32'(4 * k)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic acc(input logic w, input logic [31:0] a, input logic [31:0] d,
                       input logic c, input logic b, input logic [2:0] t);
        @(negedge clk);
        cpu_write = w; cpu_addr = a; cpu_wdata = d;
        cpu_cacheable = c; cpu_bufferable = b; cpu_tex = t; cpu_valid = 1'b1;
        do @(negedge clk); while (!cpu_done);
        last_rd   = cpu_rdata;
        cpu_valid = 1'b0;
        @(negedge clk);
        chk(!cpu_done, "R13", "done width", 32'(cpu_done), 32'd0);
    endtask

    task automatic do_flush();
        @(negedge clk) flush_req = 1'b1;
        @(negedge clk) flush_req = 1'b0;
        while (!flush_done) @(negedge clk);
        @(negedge clk);
        chk(!flush_done, "R11", "flush_done width", 32'(flush_done), 32'd0);
    endtask

    task automatic run_all();
        int base;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_valid && !cpu_done && !flush_done, "R1", "idle outputs",
            {29'd0, mem_valid, cpu_done, flush_done}, 32'd0);

        // R3: cold read misses on every line
        for (int i = 0; i < 8; i++) begin
            base = log_n;
            acc(0, A(0, i, i), 0, 1, 1, 3'd0);
            chk(log_n - base == 8, "R3", "fill beats", 32'(log_n - base), 32'd8);
            chk(burst_ok(base, 0, A(0, i, 0)), "R3", "fill order", log_addr[base], A(0, i, 0));
            chk(last_rd == init_w(A(0, i, i)), "R3", "miss data", last_rd, init_w(A(0, i, i)));
        end

        // R4: every word hits
        for (int i = 0; i < 8; i++) begin
            base = log_n; ok = 1;
            for (int w = 0; w < 8; w++) begin
                acc(0, A(0, i, w), 0, 1, w[0], 3'(w));
                if (last_rd != init_w(A(0, i, w))) ok = 0;
            end
            chk(ok && log_n == base, "R4", "hit data/no traffic", 32'(log_n - base), 32'd0);
        end

        // R5: write-back hits on lines 0..3
        for (int i = 0; i < 4; i++) begin
            base = log_n;
            acc(1, A(0, i, 3), 32'hB000_0000 | 32'(i), 1, 1, 3'd0);
            chk(log_n == base, "R5", "no mem write", 32'(log_n - base), 32'd0);
            acc(0, A(0, i, 3), 0, 1, 1, 3'd0);
            chk(last_rd == (32'hB000_0000 | 32'(i)) && log_n == base, "R5", "read back",
                last_rd, 32'hB000_0000 | 32'(i));
            chk(mw(A(0, i, 3)) == init_w(A(0, i, 3)), "R5", "memory stale",
                mw(A(0, i, 3)), init_w(A(0, i, 3)));
        end

        // R6: write-through hits on lines 4..7
        for (int i = 4; i < 8; i++) begin
            base = log_n;
            acc(1, A(0, i, 5), 32'hC000_0000 | 32'(i), 1, 0, 3'd0);
            chk(log_n - base == 1 && log_we[base] && log_addr[base] == A(0, i, 5), "R6",
                "single write", 32'(log_n - base), 32'd1);
            chk(mw(A(0, i, 5)) == (32'hC000_0000 | 32'(i)), "R6", "memory updated",
                mw(A(0, i, 5)), 32'hC000_0000 | 32'(i));
            base = log_n;
            acc(0, A(0, i, 5), 0, 1, 0, 3'd0);
            chk(last_rd == (32'hC000_0000 | 32'(i)) && log_n == base, "R6", "cache updated",
                last_rd, 32'hC000_0000 | 32'(i));
        end

        // R10: dirty victim
        base = log_n;
        acc(0, A(1, 0, 0), 0, 1, 1, 3'd0);
        chk(log_n - base == 16, "R10", "beat count", 32'(log_n - base), 32'd16);
        chk(burst_ok(base, 1, A(0, 0, 0)) && burst_ok(base + 8, 0, A(1, 0, 0)), "R10",
            "writeback then fill", log_addr[base], A(0, 0, 0));
        chk(mw(A(0, 0, 3)) == 32'hB000_0000 && mw(A(0, 0, 0)) == init_w(A(0, 0, 0)), "R10",
            "victim data", mw(A(0, 0, 3)), 32'hB000_0000);
        chk(last_rd == init_w(A(1, 0, 0)), "R10", "new data", last_rd, init_w(A(1, 0, 0)));

        // R9: clean victim
        base = log_n;
        acc(0, A(1, 4, 2), 0, 1, 1, 3'd0);
        chk(log_n - base == 8 && burst_ok(base, 0, A(1, 4, 0)), "R9", "fill only",
            32'(log_n - base), 32'd8);
        base = log_n;
        acc(0, A(0, 4, 5), 0, 1, 1, 3'd0);
        chk(log_n - base == 8 && last_rd == 32'hC000_0004, "R9", "refill sees written-through word",
            last_rd, 32'hC000_0004);

        // R8: non-allocating write misses, all tex values except 001
        base = log_n;
        acc(1, A(2, 1, 6), 32'hD100_0000, 1, 1, 3'd0);
        chk(log_n - base == 1 && log_we[base] && mw(A(2, 1, 6)) == 32'hD100_0000, "R8",
            "direct write", 32'(log_n - base), 32'd1);
        ok = 1;
        for (int t = 0; t < 8; t++) begin
            if (t == 1) continue;
            for (int b = 0; b < 2; b++) begin
                base = log_n;
                acc(1, A(3, 6, t), 32'hD600_0000 | 32'(t * 16 + b), 1, b[0], 3'(t));
                if (log_n - base != 1 || !log_we[base] || log_addr[base] != A(3, 6, t)) ok = 0;
                if (mw(A(3, 6, t)) != (32'hD600_0000 | 32'(t * 16 + b))) ok = 0;
            end
        end
        chk(ok, "R8", "tex sweep single writes", 32'(ok), 32'd1);
        base = log_n;
        acc(0, A(0, 1, 3), 0, 1, 1, 3'd0);
        acc(0, A(0, 6, 0), 0, 1, 1, 3'd0);
        chk(log_n == base && last_rd == init_w(A(0, 6, 0)), "R8", "lines unchanged",
            32'(log_n - base), 32'd0);

        // R7: allocating write misses
        base = log_n;
        acc(1, A(2, 2, 4), 32'hE200_0000, 1, 1, 3'd1);
        chk(log_n - base == 16 && burst_ok(base, 1, A(0, 2, 0)) && burst_ok(base + 8, 0, A(2, 2, 0)),
            "R7", "evict+fill, no extra write", 32'(log_n - base), 32'd16);
        chk(mw(A(0, 2, 3)) == 32'hB000_0002 && mw(A(2, 2, 4)) == init_w(A(2, 2, 4)), "R7",
            "write-back alloc memory", mw(A(2, 2, 4)), init_w(A(2, 2, 4)));
        base = log_n;
        acc(0, A(2, 2, 4), 0, 1, 1, 3'd0);
        chk(log_n == base && last_rd == 32'hE200_0000, "R7", "allocated data", last_rd, 32'hE200_0000);
        base = log_n;
        acc(1, A(2, 5, 1), 32'hE500_0000, 1, 0, 3'd1);
        chk(log_n - base == 9 && burst_ok(base, 0, A(2, 5, 0)) && log_we[base+8] &&
            log_addr[base+8] == A(2, 5, 1) && mw(A(2, 5, 1)) == 32'hE500_0000, "R7",
            "fill then write-through", 32'(log_n - base), 32'd9);

        // R2: uncached accesses over attribute combinations
        for (int k = 0; k < 4; k++) begin
            ok = 1;
            base = log_n;
            acc(1, A(0, 3, 3), 32'hF300_0000 | 32'(k), 0, k[0], {2'b0, k[1]});
            if (log_n - base != 1 || !log_we[base] || log_addr[base] != A(0, 3, 3)) ok = 0;
            base = log_n;
            acc(0, A(0, 3, 3), 0, 0, k[1], {2'b0, k[0]});
            if (log_n - base != 1 || log_we[base] || last_rd != (32'hF300_0000 | 32'(k))) ok = 0;
            base = log_n;
            acc(0, A(0, 3, 3), 0, 1, 1, 3'd0);
            if (log_n != base || last_rd != 32'hB000_0003) ok = 0;
            chk(ok, "R2", "bypass single transfer, cache kept", last_rd, 32'hB000_0003);
        end

        // R11: flush writes dirty lines 1,2,3 in order
        base = log_n;
        do_flush();
        chk(log_n - base == 24 && burst_ok(base, 1, A(0, 1, 0)) && burst_ok(base + 8, 1, A(2, 2, 0))
            && burst_ok(base + 16, 1, A(0, 3, 0)), "R11", "flush bursts", 32'(log_n - base), 32'd24);
        chk(mw(A(0, 1, 3)) == 32'hB000_0001 && mw(A(2, 2, 4)) == 32'hE200_0000 &&
            mw(A(0, 3, 3)) == 32'hB000_0003, "R11", "flushed data", mw(A(0, 3, 3)), 32'hB000_0003);
        base = log_n;
        do_flush();
        chk(log_n == base, "R11", "second flush idle", 32'(log_n - base), 32'd0);
        base = log_n;
        acc(0, A(1, 3, 0), 0, 1, 1, 3'd0);
        chk(log_n - base == 8 && burst_ok(base, 0, A(1, 3, 0)), "R11", "dirty bit cleared",
            32'(log_n - base), 32'd8);

        @(negedge clk);
        chk(stall_viol == 0 && stalls > 0, "R12", "stall hold", 32'(stall_viol), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule